// File: doc/BRIEF.md
# Carry-Mode 32-bit ALU

This block is a registered 32-bit arithmetic and logic unit that keeps a persistent carry flag between operations. It offers four add/subtract flavours that differ only in their carry handling. One pair chains with the stored carry and then clears it. One pair chains with the stored carry and saves the new carry or borrow. One pair ignores the stored carry and leaves it alone. The last pair ignores the stored carry and clears it. Multi-word arithmetic is built by issuing the chaining unsigned flavour once for each word.

It also provides bitwise AND, OR and XOR, and a bound-check operation. Bound check computes left minus right to produce its flags but returns the left operand unchanged. Every operation reports the raw adder carry-out and a signed overflow flag.

An operation is accepted on a rising clock edge while `valid_i` is high, and its outputs appear in registers after that edge. A reject or trap qualifier arriving with the operation still lets the result registers load. It blocks any change to the stored carry, so the operation can be replayed against the same carry.

Top module: `alu_carry`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every output is zero, including the stored carry `carry_o`, until the first accepted operation.
- R2: Result, carry-out, overflow and bad-op outputs load only on a rising edge with `valid_i` high. With `valid_i` low they hold their values and `carry_o` does not change.
- R3: Opcode encoding on `op_i`: 0 SADD, 1 SSUB, 2 UADD, 3 USUB, 4 VADD, 5 VSUB, 6 LADD, 7 LSUB, 8 AND, 9 OR, 10 XOR, 11 BNDCHK. The add flavours compute left + right + cin. cin is the stored carry for SADD and UADD, and 0 for VADD and LADD.
- R4: The subtract flavours compute left + ~right + ~cin. cin is the stored carry for SSUB and USUB, and 0 for VSUB and LSUB. For every add and subtract, `carry_out_o` is bit 32 of that adder sum.
- R5: Carry writeback on an accepted, committed operation works as follows. SADD, SSUB, LADD and LSUB clear the carry. UADD stores the adder carry-out. USUB stores its inverse. VADD, VSUB, the logic operations and BNDCHK leave the carry unchanged.
- R6: The stored carry does not change when `reject_i` or `trap_i` is high with the operation, even though the result outputs still load.
- R7: BNDCHK returns the left operand as the result. `carry_out_o` is the carry of left + ~right + 1, and overflow is evaluated on that difference with the right operand not negated.
- R8: AND, OR and XOR return the bitwise function of the operands with `carry_out_o` = 0.
- R9: Overflow is 1 when the sign bit of left equals the sign bit of the effective right operand and the sign bit of the adder or logic output differs from the sign bit of left. The effective right operand is the two's complement negation of right for the four subtracts and right itself otherwise.
- R10: Codes 12 to 15 give result 0, `bad_op_o` = 1, carry-out 0, overflow 0, and leave the stored carry unchanged. Every defined code gives `bad_op_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| reject_i | input | 1 | Reject qualifier, blocks carry commit |
| trap_i | input | 1 | Trap-condition qualifier, blocks carry commit |
| op_i | input | 4 | Opcode (see R3) |
| left_i | input | 32 | Left operand |
| right_i | input | 32 | Right operand |
| result_o | output | 32 | Registered result |
| carry_out_o | output | 1 | Registered raw adder carry-out |
| overflow_o | output | 1 | Registered signed overflow |
| bad_op_o | output | 1 | Registered undefined-opcode flag |
| carry_o | output | 1 | Stored carry flag |

## Verification
Directed sequences come first. An all-ones unsigned add sets the carry, and a following zero add shows that carry chaining in. A zero-minus-one unsigned subtract stores a borrow. Signed and L-flavour operations show the clear rule, and V-flavour operations show the carry left untouched. The sign-boundary operands 0x7FFFFFFF and 0x80000000 separate the negated and non-negated overflow rules for subtract and bound check. Reject, trap and idle cycles are issued right after a carry-setting operation, so that a design which commits the carry anyway gives a different `carry_o`. A long random run over every opcode, including the undefined ones, covers every pair of carry flavours applied one after another.

// File: rtl/alu_carry_pkg.sv
package alu_carry_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_UADD   = 4'd2,
    OP_USUB   = 4'd3,
    OP_VADD   = 4'd4,
    OP_VSUB   = 4'd5,
    OP_LADD   = 4'd6,
    OP_LSUB   = 4'd7,
    OP_AND    = 4'd8,
    OP_OR     = 4'd9,
    OP_XOR    = 4'd10,
    OP_BNDCHK = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    CWB_KEEP  = 2'd0,
    CWB_CLEAR = 2'd1,
    CWB_SAVE  = 2'd2,
    CWB_INV   = 2'd3
  } cwb_e;

  typedef enum logic [1:0] {
    OUT_ADD  = 2'd0,
    OUT_LOG  = 2'd1,
    OUT_LEFT = 2'd2,
    OUT_ZERO = 2'd3
  } osel_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2
  } lfn_e;

  typedef struct packed {
    logic  use_carry; // take stored carry as cin
    logic  sub;       // invert right and cin
    logic  neg_ovf;   // negate right for overflow
    cwb_e  cwb;
    osel_e osel;
    lfn_e  lfn;
    logic  bad;
  } ctrl_t;
endpackage

// File: rtl/alu_carry_ctrl.sv
module alu_carry_ctrl
  import alu_carry_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o = '{use_carry: 1'b0, sub: 1'b0, neg_ovf: 1'b0, cwb: CWB_KEEP,
               osel: OUT_ZERO, lfn: LOG_AND, bad: 1'b0};
    case (op_i)
      OP_SADD:   begin ctrl_o.use_carry = 1'b1; ctrl_o.cwb = CWB_CLEAR; ctrl_o.osel = OUT_ADD; end
      OP_SSUB:   begin ctrl_o.use_carry = 1'b1; ctrl_o.sub = 1'b1; ctrl_o.neg_ovf = 1'b1;
                       ctrl_o.cwb = CWB_CLEAR; ctrl_o.osel = OUT_ADD; end
      OP_UADD:   begin ctrl_o.use_carry = 1'b1; ctrl_o.cwb = CWB_SAVE; ctrl_o.osel = OUT_ADD; end
      OP_USUB:   begin ctrl_o.use_carry = 1'b1; ctrl_o.sub = 1'b1; ctrl_o.neg_ovf = 1'b1;
                       ctrl_o.cwb = CWB_INV; ctrl_o.osel = OUT_ADD; end
      OP_VADD:   ctrl_o.osel = OUT_ADD;
      OP_VSUB:   begin ctrl_o.sub = 1'b1; ctrl_o.neg_ovf = 1'b1; ctrl_o.osel = OUT_ADD; end
      OP_LADD:   begin ctrl_o.cwb = CWB_CLEAR; ctrl_o.osel = OUT_ADD; end
      OP_LSUB:   begin ctrl_o.sub = 1'b1; ctrl_o.neg_ovf = 1'b1; ctrl_o.cwb = CWB_CLEAR;
                       ctrl_o.osel = OUT_ADD; end
      OP_AND:    begin ctrl_o.osel = OUT_LOG; ctrl_o.lfn = LOG_AND; end
      OP_OR:     begin ctrl_o.osel = OUT_LOG; ctrl_o.lfn = LOG_OR; end
      OP_XOR:    begin ctrl_o.osel = OUT_LOG; ctrl_o.lfn = LOG_XOR; end
      OP_BNDCHK: begin ctrl_o.sub = 1'b1; ctrl_o.osel = OUT_LEFT; end // flags from l-r, no negation
      default:   ctrl_o.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_carry_adder.sv
module alu_carry_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] full;
  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign sum_o  = full[WIDTH-1:0];
  assign cout_o = full[WIDTH];
endmodule

// File: rtl/alu_carry_logic.sv
module alu_carry_logic
  import alu_carry_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  lfn_e             fn_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    case (fn_i)
      LOG_OR:  y_o = a_i | b_i;
      LOG_XOR: y_o = a_i ^ b_i;
      default: y_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/alu_carry.sv
module alu_carry
  import alu_carry_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             reject_i,
  input  logic             trap_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] left_i,
  input  logic [WIDTH-1:0] right_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_out_o,
  output logic             overflow_o,
  output logic             bad_op_o,
  output logic             carry_o
);
  localparam int unsigned MSB = WIDTH - 1;

  ctrl_t            ctrl;
  logic [WIDTH-1:0] b_in, sum, log_y, alu_out, res_d, eff_right;
  logic             cin, cout, ovf_d, cout_d, carry_d, commit;
  logic [WIDTH-1:0] result_q;
  logic             cout_q, ovf_q, bad_q, carry_q;

  alu_carry_ctrl u_ctrl (.op_i(op_i), .ctrl_o(ctrl));

  assign b_in = ctrl.sub ? ~right_i : right_i;
  assign cin  = (ctrl.use_carry & carry_q) ^ ctrl.sub;

  alu_carry_adder #(.WIDTH(WIDTH)) u_add (
    .a_i(left_i), .b_i(b_in), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  alu_carry_logic #(.WIDTH(WIDTH)) u_log (
    .a_i(left_i), .b_i(right_i), .fn_i(ctrl.lfn), .y_o(log_y)
  );

  assign alu_out   = (ctrl.osel == OUT_LOG) ? log_y : sum;
  assign eff_right = ctrl.neg_ovf ? (~right_i + {{MSB{1'b0}}, 1'b1}) : right_i;

  always_comb begin
    case (ctrl.osel)
      OUT_ADD:  res_d = sum;
      OUT_LOG:  res_d = log_y;
      OUT_LEFT: res_d = left_i;
      default:  res_d = '0;
    endcase
  end

  assign cout_d = (ctrl.osel == OUT_ADD || ctrl.osel == OUT_LEFT) ? cout : 1'b0;
  assign ovf_d  = !ctrl.bad && (left_i[MSB] == eff_right[MSB]) && (alu_out[MSB] != left_i[MSB]);

  always_comb begin
    case (ctrl.cwb)
      CWB_CLEAR: carry_d = 1'b0;
      CWB_SAVE:  carry_d = cout;
      CWB_INV:   carry_d = ~cout;
      default:   carry_d = carry_q;
    endcase
  end

  assign commit = valid_i && !reject_i && !trap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      cout_q   <= 1'b0;
      ovf_q    <= 1'b0;
      bad_q    <= 1'b0;
    end else if (valid_i) begin
      result_q <= res_d;
      cout_q   <= cout_d;
      ovf_q    <= ovf_d;
      bad_q    <= ctrl.bad;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     carry_q <= 1'b0;
    else if (commit) carry_q <= carry_d;
  end

  assign result_o    = result_q;
  assign carry_out_o = cout_q;
  assign overflow_o  = ovf_q;
  assign bad_op_o    = bad_q;
  assign carry_o     = carry_q;

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(carry_o) && $stable(bad_op_o));

  assert_clear_flavour_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !reject_i && !trap_i &&
     op_i inside {OP_SADD, OP_SSUB, OP_LADD, OP_LSUB}) |=> !carry_o);

  assert_keep_flavour_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i inside {OP_VADD, OP_VSUB, OP_AND, OP_OR, OP_XOR, OP_BNDCHK})
    |=> $stable(carry_o));

  assert_no_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reject_i || trap_i) |=> $stable(carry_o));

  assert_bndchk_left_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_BNDCHK) |=> result_o == $past(left_i));

  assert_bad_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > OP_BNDCHK) |=> bad_op_o && result_o == '0 && !overflow_o
                                     && !carry_out_o && $stable(carry_o));
endmodule

// File: tb/alu_carry_tb.sv
module alu_carry_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0, reject = 1'b0, trap = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] left = '0, right = '0;
  logic [W-1:0] result;
  logic         carry_out, overflow, bad_op, carry;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;

  logic [W-1:0] m_res = '0;
  logic         m_cout = 1'b0, m_ovf = 1'b0, m_bad = 1'b0, m_carry = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_carry u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .reject_i(reject), .trap_i(trap),
    .op_i(op), .left_i(left), .right_i(right), .result_o(result),
    .carry_out_o(carry_out), .overflow_o(overflow), .bad_op_o(bad_op), .carry_o(carry)
  );

  function automatic string tag_of(input logic [3:0] o, input logic v, input logic rj, input logic tp);
    if (!v) return "R2";
    if (rj || tp) return "R6";
    case (o)
      4'd0, 4'd2, 4'd4, 4'd6: return "R3";
      4'd1, 4'd5, 4'd7:       return "R4";
      4'd3:                   return "R5";
      4'd8, 4'd9, 4'd10:      return "R8";
      4'd11:                  return "R7";
      default:                return "R10";
    endcase
  endfunction

  // reference model from the requirements
  task automatic model(input logic [3:0] o, input logic [W-1:0] l, input logic [W-1:0] r,
                       input logic v, input logic rj, input logic tp);
    logic [W:0]   s;
    logic [W-1:0] ao, effr, res;
    logic         cin, co, ov, bad, nc;
    bad = 1'b0; co = 1'b0; nc = m_carry; effr = r; s = '0;
    cin = (o <= 4'd3) ? m_carry : 1'b0;
    if (o <= 4'd7 && !o[0]) begin
      s = {1'b0, l} + {1'b0, r} + {{W{1'b0}}, cin};
    end else if (o <= 4'd7 || o == 4'd11) begin
      s = {1'b0, l} + {1'b0, ~r} + {{W{1'b0}}, ~cin};
      if (o != 4'd11) effr = -r;
    end
    ao = s[W-1:0];
    case (o)
      4'd8:  ao = l & r;
      4'd9:  ao = l | r;
      4'd10: ao = l ^ r;
      default: ;
    endcase
    if (o <= 4'd7 || o == 4'd11) co = s[W];
    res = (o == 4'd11) ? l : ao;
    if (o > 4'd11) begin bad = 1'b1; res = '0; end
    ov = !bad && (l[W-1] == effr[W-1]) && (ao[W-1] != l[W-1]);
    case (o)
      4'd0, 4'd1, 4'd6, 4'd7: nc = 1'b0;
      4'd2: nc = s[W];
      4'd3: nc = ~s[W];
      default: ;
    endcase
    if (v) begin m_res = res; m_cout = co; m_ovf = ov; m_bad = bad; end
    if (v && !rj && !tp) m_carry = nc;
  endtask

  task automatic check(input string tag);
    n_checks++;
    if (result !== m_res || carry_out !== m_cout || overflow !== m_ovf ||
        bad_op !== m_bad || carry !== m_carry) begin
      n_fail++;
      $display("FAIL %s op=%0d actual res=%h co=%b ov=%b bad=%b c=%b expected res=%h co=%b ov=%b bad=%b c=%b",
               tag, op, result, carry_out, overflow, bad_op, carry,
               m_res, m_cout, m_ovf, m_bad, m_carry);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [W-1:0] l, input logic [W-1:0] r,
                       input logic v, input logic rj, input logic tp);
    string t;
    @(negedge clk);
    op = o; left = l; right = r; valid = v; reject = rj; trap = tp;
    t = tag_of(o, v, rj, tp);
    model(o, l, r, v, rj, tp);
    @(negedge clk);
    valid = 1'b0; reject = 1'b0; trap = 1'b0;
    check(t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1"); // reset state while held
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    // R3 R5: unsigned chain
    issue(4'd2, 32'hFFFF_FFFF, 32'h1, 1, 0, 0);
    issue(4'd2, 32'h0, 32'h0, 1, 0, 0);
    // R6: set carry, then reject and trap must not clear it
    issue(4'd2, 32'hFFFF_FFFF, 32'h2, 1, 0, 0);
    issue(4'd0, 32'h5, 32'h6, 1, 1, 0);
    issue(4'd6, 32'h5, 32'h6, 1, 0, 1);
    // R2: idle cycle holds
    issue(4'd0, 32'h1234, 32'h1, 0, 0, 0);
    // R5: V flavour keeps, S clears after chaining
    issue(4'd4, 32'h10, 32'h20, 1, 0, 0);
    issue(4'd5, 32'h10, 32'h20, 1, 0, 0);
    issue(4'd0, 32'h10, 32'h20, 1, 0, 0);
    // R4 R5: borrow store then chained signed subtract
    issue(4'd3, 32'h0, 32'h1, 1, 0, 0);
    issue(4'd1, 32'h10, 32'h1, 1, 0, 0);
    // R9: overflow corners
    issue(4'd4, 32'h7FFF_FFFF, 32'h1, 1, 0, 0);
    issue(4'd5, 32'h8000_0000, 32'h1, 1, 0, 0);
    issue(4'd7, 32'h0, 32'h8000_0000, 1, 0, 0);
    // R7: bound check
    issue(4'd11, 32'h8000_0000, 32'h1, 1, 0, 0);
    issue(4'd11, 32'h0000_0005, 32'h0000_0009, 1, 0, 0);
    // R8 logic ops
    issue(4'd8, 32'hF0F0_1234, 32'hFF00_FF00, 1, 0, 0);
    issue(4'd9, 32'h8000_0000, 32'h0000_0001, 1, 0, 0);
    issue(4'd10, 32'hAAAA_AAAA, 32'h5555_5555, 1, 0, 0);
    // R10 undefined codes
    issue(4'd2, 32'hFFFF_FFFF, 32'h1, 1, 0, 0);
    for (int k = 12; k < 16; k++) issue(4'(k), 32'hDEAD_BEEF, 32'h1, 1, 0, 0);
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]   ro;
      logic [W-1:0] rl, rr;
      int unsigned  pick;
      ro = 4'($urandom_range(0, 15));
      pick = $urandom_range(0, 7);
      rl = (pick == 0) ? 32'h7FFF_FFFF : (pick == 1) ? 32'h8000_0000 : $urandom;
      pick = $urandom_range(0, 7);
      rr = (pick == 0) ? 32'hFFFF_FFFF : (pick == 1) ? 32'h0 : $urandom;
      issue(ro, rl, rr, ($urandom_range(0, 7) != 0), ($urandom_range(0, 9) == 0),
            ($urandom_range(0, 9) == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule